// File: doc/BRIEF.md
# Sequential Shift-Subtract Divider

This block divides an unsigned 8-bit dividend by an unsigned 4-bit divisor. It produces a 4-bit quotient and a 4-bit remainder, and it works one bit at a time over several clock cycles. A single working register is one bit wider than the dividend. Each step shifts that register left. The upper five bits are then compared with the divisor, and the divisor is subtracted when it fits. The quotient bit for that step goes into the lowest position, which the shift has just vacated. When all steps are done, the low four bits of the register hold the quotient and the next four bits hold the remainder.

A request is a one-cycle `start` with the operands. The block then spends one cycle checking for overflow. If the top five bits of the loaded register are already greater than or equal to the divisor, the quotient cannot fit in four bits. In that case the block stops at once and reports overflow. A divisor of zero always takes this path. Otherwise four shift-and-subtract cycles follow. Completion is marked by a one-cycle `done`. The sequencer is a one-hot state machine, and it ignores `start` until it is idle again.

Top module: `shsub_divider`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `busy`, `done` and `overflow` are all 0.
- R2: For a dividend D and a non-zero divisor V with D/16 < V, a start accepted at clock edge k gives `done`=1 with `overflow`=0 after edge k+5. At that point `quotient` = D/V and `remainder` = D mod V.
- R3: When the upper four dividend bits D[7:4] are greater than or equal to the divisor, a start accepted at edge k gives `done`=1 and `overflow`=1 after edge k+1, and no division steps are taken.
- R4: A divisor of 0 is always reported as overflow, with the same timing as R3.
- R5: `done` is high for exactly one cycle per accepted start.
- R6: A `start` raised while `busy` is 1 is ignored. The running job keeps its operands, its results and its timing, and no extra `done` follows.
- R7: A `start` in the cycle where `done` is high is accepted. The next job then follows with no idle cycle in between.
- R8: `overflow`, `quotient` and `remainder` keep their completion values until the next accepted start.
- R9: `busy` is 1 from the cycle after a start is accepted until the cycle before `done`, and it is 0 while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; sampled only while idle |
| dividend | input | 8 | Unsigned dividend, captured with an accepted start |
| divisor | input | 4 | Unsigned divisor, captured with an accepted start |
| busy | output | 1 | A division or overflow check is in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Quotient would not fit in 4 bits (or divisor is 0); held until next start |
| quotient | output | 4 | Quotient, valid from `done` onward |
| remainder | output | 4 | Remainder, valid from `done` onward |

## Verification
Two functions can fall in the same cycle: the completion pulse of one job and the acceptance of the next start. The bench provokes this by driving a new request in exactly the cycle where `done` is seen, for every dividend and divisor pair, with normal and overflow results mixed. The judge is each job's own completion cycle, worked out from its acceptance cycle, together with its quotient, remainder and overflow flag. Any lost, repeated or shifted job shows up as a mismatch in the scoreboard.

// File: rtl/shsub_div_pkg.sv
`timescale 1ns/1ps
// Package: shared state indices and sizing helpers for the shift-subtract divider.
// Assumes the one-hot controller orders its states as idle, check, then the step chain.
package shsub_div_pkg;
    localparam int ST_IDLE  = 0;
    localparam int ST_CHECK = 1;
    localparam int ST_STEP0 = 2;

    // Number of one-hot states for a quotient of qw bits.
    function automatic int state_count(input int qw);
        return qw + 2;
    endfunction
endpackage

// File: rtl/shsub_div_ctrl.sv
`timescale 1ns/1ps
// Module: one-hot sequencer for the divider.
// Flow: idle -> check (overflow test) -> QW step states -> idle.
// Assumes cmp_ge comes from the datapath and reflects the register loaded on entry to check.
module shsub_div_ctrl
    import shsub_div_pkg::*;
#(
    parameter int QW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cmp_ge,
    output logic load,
    output logic step,
    output logic busy,
    output logic done,
    output logic overflow
);
    localparam int NS   = state_count(QW);
    localparam int LAST = NS - 1;

    logic [NS-1:0] st_q, st_d;
    logic          done_q, ovf_q;
    logic          ovf_hit;

    assign load    = st_q[ST_IDLE] & start;
    assign step    = |st_q[LAST:ST_STEP0];
    assign busy    = ~st_q[ST_IDLE];
    assign ovf_hit = st_q[ST_CHECK] & cmp_ge;
    assign done     = done_q;
    assign overflow = ovf_q;

    // Next-state decode: each one-hot bit hands on to its successor.
    always_comb begin
        st_d = '0;
        if (st_q[ST_IDLE]) begin
            if (start) st_d[ST_CHECK] = 1'b1;
            else       st_d[ST_IDLE]  = 1'b1;
        end
        if (st_q[ST_CHECK]) begin
            if (cmp_ge) st_d[ST_IDLE]  = 1'b1;
            else        st_d[ST_STEP0] = 1'b1;
        end
        for (int i = ST_STEP0; i < LAST; i++) begin
            if (st_q[i]) st_d[i+1] = 1'b1;
        end
        if (st_q[LAST]) st_d[ST_IDLE] = 1'b1;
    end

    // State register with synchronous reset into idle.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= NS'(1) << ST_IDLE;
        else        st_q <= st_d;
    end

    // Completion pulse and sticky overflow flag, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            done_q <= ovf_hit | st_q[LAST];
            if (load)         ovf_q <= 1'b0;
            else if (ovf_hit) ovf_q <= 1'b1;
        end
    end

    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q) == 1);                                        // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                               // R5
    AST_EARLY_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step && cmp_ge) |=> (done && overflow));             // R3
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !st_q[LAST] && start) |=> (busy && !done));           // R6
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !st_q[ST_CHECK]) |=> $stable(overflow));             // R8
endmodule

// File: rtl/shsub_div_datapath.sv
`timescale 1ns/1ps
// Module: working register, divisor register, comparator and subtractor.
// The register is DVD_W+1 bits; its upper DVS_W+1 bits are the partial remainder
// and its low QW bits fill with quotient bits as each left shift frees them.
// Assumes load and step are never high together.
module shsub_div_datapath #(
    parameter int DVD_W = 8,
    parameter int DVS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [DVD_W-1:0] dvd_in,
    input  logic [DVS_W-1:0] dvs_in,
    output logic             cmp_ge,
    output logic [DVD_W:0]   x_out,
    output logic [DVS_W-1:0] dvs_out
);
    localparam int REG_W = DVD_W + 1;
    localparam int UW    = DVS_W + 1;
    localparam int QW    = DVD_W - DVS_W;

    logic [REG_W-1:0] x_q, x_sh, x_nx;
    logic [DVS_W-1:0] y_q;
    logic [UW-1:0]    y_ext, sh_up;
    logic             sh_ge;

    assign y_ext = {1'b0, y_q};
    // Overflow comparator on the register as it stands (used in the check state).
    assign cmp_ge = (x_q[REG_W-1:QW] >= y_ext);

    // One step: shift left, then compare and conditionally subtract, setting the freed bit.
    always_comb begin
        x_sh  = {x_q[REG_W-2:0], 1'b0};
        sh_up = x_sh[REG_W-1:QW];
        sh_ge = (sh_up >= y_ext);
        x_nx  = x_sh;
        if (sh_ge) begin
            x_nx[REG_W-1:QW] = sh_up - y_ext;
            x_nx[0]          = 1'b1;
        end
    end

    // Register update: capture operands on load, advance on step, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (load) begin
            x_q <= {1'b0, dvd_in};
            y_q <= dvs_in;
        end else if (step) begin
            x_q <= x_nx;
        end
    end

    assign x_out   = x_q;
    assign dvs_out = y_q;

    AST_STEP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (x_q[REG_W-1] == 1'b0));                              // R2
    AST_DIVISOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(y_q));                                        // R6
endmodule

// File: rtl/shsub_divider.sv
`timescale 1ns/1ps
// Module: top of the sequential unsigned shift-subtract divider.
// Joins the one-hot sequencer and the datapath; results are read straight
// from the working register (quotient low bits, remainder above them).
// Assumes start is a level sampled only while idle.
module shsub_divider #(
    parameter int DVD_W = 8,
    parameter int DVS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             overflow,
    output logic [DVD_W-DVS_W-1:0] quotient,
    output logic [DVS_W-1:0] remainder
);
    localparam int QW = DVD_W - DVS_W;

    logic           load, step, cmp_ge;
    logic [DVD_W:0] x_reg;
    logic [DVS_W-1:0] dvs_q;

    shsub_div_ctrl #(.QW(QW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmp_ge   (cmp_ge),
        .load     (load),
        .step     (step),
        .busy     (busy),
        .done     (done),
        .overflow (overflow)
    );

    shsub_div_datapath #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .dvd_in  (dividend),
        .dvs_in  (divisor),
        .cmp_ge  (cmp_ge),
        .x_out   (x_reg),
        .dvs_out (dvs_q)
    );

    assign quotient  = x_reg[QW-1:0];
    assign remainder = x_reg[DVD_W-1:QW];

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !overflow) |-> (remainder < dvs_q));                  // R2
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                               // R9
endmodule

// File: tb/shsub_divider_test.sv
`timescale 1ns/1ps
module shsub_divider_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] dividend = '0;
    logic [3:0] divisor = '0;
    logic       busy, done, overflow;
    logic [3:0] quotient, remainder;

    typedef struct {
        logic       ovf;
        logic [3:0] q;
        logic [3:0] r;
        int         due;
        string      tag;
    } exp_t;

    exp_t sb[$];
    exp_t last_exp;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    logic prev_done = 1'b0;
    logic run_mon = 1'b0;

    shsub_divider uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .busy(busy), .done(done), .overflow(overflow),
        .quotient(quotient), .remainder(remainder)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: waits for idle, drives one request, pushes the expected result.
    task automatic issue(input logic [7:0] d, input logic [3:0] v, input string tag_in);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        e.ovf = (v == 0) || (d[7:4] >= v);
        e.q   = e.ovf ? 4'd0 : 4'(d / v);
        e.r   = e.ovf ? 4'd0 : 4'(d % v);
        e.due = cyc + (e.ovf ? 2 : 6);
        if (tag_in != "") e.tag = tag_in;
        else if (done)    e.tag = "R7";
        else if (v == 0)  e.tag = "R4";
        else if (e.ovf)   e.tag = "R3";
        else              e.tag = "R2";
        start = 1'b1; dividend = d; divisor = v;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Issue a normal job, then hammer start with other operands while busy (R6).
    task automatic issue_with_noise(input logic [7:0] d, input logic [3:0] v);
        issue(d, v, "R6");
        for (int k = 0; k < 3; k++) begin
            start = 1'b1; dividend = 8'h0F; divisor = 4'h1;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    // R8: outputs stay at completion values while idle.
    task automatic check_hold();
        repeat (4) @(negedge clk);
        check(overflow == last_exp.ovf, "R8", "overflow held", overflow, last_exp.ovf);
        check(!done, "R8", "no done while idle", done, 0);
        if (!last_exp.ovf) begin
            check(quotient == last_exp.q, "R8", "quotient held", quotient, last_exp.q);
            check(remainder == last_exp.r, "R8", "remainder held", remainder, last_exp.r);
        end
    endtask

    // Monitor: pops the scoreboard on done and checks timing, busy and values.
    always @(negedge clk) begin
        if (run_mon) begin
            if (done) begin
                check(!prev_done, "R5", "done longer than one cycle", 1, 0);
                if (sb.size() == 0) begin
                    check(0, "R6", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(cyc == e.due, e.tag, "done cycle", cyc, e.due);
                    check(overflow == e.ovf, e.tag, "overflow", overflow, e.ovf);
                    if (!e.ovf) begin
                        check(quotient == e.q, e.tag, "quotient", quotient, e.q);
                        check(remainder == e.r, e.tag, "remainder", remainder, e.r);
                    end
                    last_exp = e;
                end
            end else if (sb.size() != 0) begin
                if (cyc >= sb[0].due) begin
                    check(0, sb[0].tag, "done missing", cyc, sb[0].due);
                    void'(sb.pop_front());
                end else if (cyc >= sb[0].due - (sb[0].ovf ? 1 : 5)) begin
                    check(busy, "R9", "busy during job", busy, 1);
                end
            end else begin
                check(!busy, "R9", "busy while idle", busy, 0);
            end
            prev_done = done;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(4 * 60000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !overflow, "R1", "outputs in reset",
              {busy, done, overflow}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !overflow, "R1", "outputs after reset",
              {busy, done, overflow}, 0);
        run_mon = 1'b1;

        issue(8'd135, 4'd13, "R2");
        drain(); check_hold();
        issue(8'd200, 4'd7, "R3");
        drain(); check_hold();
        issue(8'd77, 4'd0, "R4");
        drain(); check_hold();
        issue(8'd239, 4'd15, "R2");
        issue(8'd240, 4'd15, "R3");
        issue(8'd0, 4'd1, "R2");
        issue_with_noise(8'd100, 4'd9);
        drain();
        issue(8'd15, 4'd1, "R2");
        issue(8'd16, 4'd1, "R3");
        drain();

        for (int d = 0; d < 256; d++) begin
            for (int v = 0; v < 16; v++) begin
                issue(8'(d), 4'(v), "");
            end
        end
        drain();
        check_hold();

        run_mon = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule